// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit turns a decoded addressing-mode descriptor into a 32-bit effective address, which is an offset within a segment. Each descriptor gives a mode code, a base register value, an index register value, a 2-bit scale code and a displacement field. The displacement field is 8, 16 or 32 bits wide and is sign-extended before it is added. The unit supports five forms:

- direct: the address comes from the displacement alone;
- register-indirect;
- base plus displacement;
- base plus scaled index;
- base plus scaled index plus displacement.

One adder stage builds the sum. The result is stored in a register and appears on the output one clock after the request, marked by a valid flag. The unit does not add a segment base, does not check limits and does not decode instructions. The surrounding pipeline presents one descriptor per cycle and reads the address back on the next cycle.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `ea` is 0.
- R2: `out_valid` is 1 in the cycle after a rising clock edge that sampled `in_valid` high, and 0 after an edge that sampled it low.
- R3: When `in_valid` is low at a clock edge, `ea` keeps its previous value whatever the other inputs are.
- R4: Mode code 0 (direct) gives `ea` = the extended displacement. `base`, `index` and `scale` have no effect.
- R5: Mode code 1 (register-indirect) gives `ea` = `base`. `index`, `scale`, `disp` and `disp_size` have no effect.
- R6: Mode code 2 gives `ea` = `base` + extended displacement. `index` and `scale` have no effect.
- R7: Mode code 3 gives `ea` = `base` + (`index` shifted left by `scale`). The displacement has no effect. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. The scale applies only to the index operand.
- R8: Mode code 4 gives `ea` = `base` + (`index` shifted left by `scale`) + extended displacement.
- R9: Displacement extension depends on `disp_size`:
  - code 0: `disp[7:0]` sign-extended to 32 bits;
  - code 1: `disp[15:0]` sign-extended to 32 bits;
  - codes 2 and 3: all 32 bits.
  Bits above the selected width have no effect.
- R10: All sums wrap modulo 2^32, and no overflow is signalled.
- R11: Reserved mode codes 5, 6 and 7 give `ea` = 0 and still raise `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor present this cycle |
| mode | input | 3 | Addressing form code (0..4, 5..7 reserved) |
| disp_size | input | 2 | Displacement width code (0: 8, 1: 16, 2/3: 32 bits) |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index shift amount (0..3) |
| disp | input | 32 | Displacement field, right-aligned |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| ea | output | 32 | Registered effective address |

## Verification
The bench sweeps every pair of mode code and displacement-size code against every scale code, using operand patterns chosen to expose three kinds of fault:

- Negative 8-bit and 16-bit displacements with garbage in the upper bits. A design that zero-extends, or that does not mask those bits, returns an address off by a multiple of 256 or 65536.
- Base and index values near 2^32. A design that saturates, or that lets the scale leak into the base, gives a wrong wrapped sum.
- Nonzero index and displacement values in the modes that must ignore them. A design that adds an operand the mode does not select is caught there.

Separate checks confirm three more behaviours:

- `ea` holds while `in_valid` is low.
- The reserved mode codes produce zero.
- The reset state is correct.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        EA_DIRECT         = 3'd0,
        EA_INDIRECT       = 3'd1,
        EA_BASE_DISP      = 3'd2,
        EA_BASE_INDEX     = 3'd3,
        EA_BASE_INDEX_DSP = 3'd4
    } ea_mode_e;

    typedef enum logic [1:0] {
        DSZ_BYTE = 2'd0,
        DSZ_HALF = 2'd1,
        DSZ_FULL = 2'd2,
        DSZ_ALT  = 2'd3
    } ea_dsize_e;

    // operand enables chosen by the mode decoder
    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_disp;
    } ea_sel_t;

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 8,
    parameter int MID_W    = 16
) (
    input  logic [ADDR_W-1:0] disp_raw,
    input  logic [1:0]        size_code,
    output logic [ADDR_W-1:0] disp_ext
);
    import ea_pkg::*;

    localparam int N_FORMS = 3;

    logic [ADDR_W-1:0] forms [N_FORMS];

    // one candidate per supported displacement width
    generate
        for (genvar g = 0; g < N_FORMS; g++) begin : g_form
            localparam int FW = (g == 0) ? NARROW_W : (g == 1) ? MID_W : ADDR_W;
            if (FW < ADDR_W) begin : g_narrow
                assign forms[g] = {{(ADDR_W-FW){disp_raw[FW-1]}}, disp_raw[FW-1:0]};
            end else begin : g_full
                assign forms[g] = disp_raw;
            end
        end
    endgenerate

    always_comb begin
        unique case (ea_dsize_e'(size_code))
            DSZ_BYTE: disp_ext = forms[0];
            DSZ_HALF: disp_ext = forms[1];
            default:  disp_ext = forms[2];
        endcase
    end

endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
    parameter int ADDR_W  = 32,
    parameter int SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  index_raw,
    input  logic [SCALE_W-1:0] scale_code,
    output logic [ADDR_W-1:0]  index_scaled
);
    localparam int N_SHIFTS = 1 << SCALE_W;

    logic [ADDR_W-1:0] shifted [N_SHIFTS];

    // fixed-shift candidates, then a single select (no barrel shifter)
    generate
        for (genvar s = 0; s < N_SHIFTS; s++) begin : g_shift
            if (s == 0) begin : g_none
                assign shifted[s] = index_raw;
            end else begin : g_some
                assign shifted[s] = {index_raw[ADDR_W-1-s:0], {s{1'b0}}};
            end
        end
    endgenerate

    assign index_scaled = shifted[scale_code];

endmodule

// File: rtl/ea_sum3.sv
module ea_sum3 #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] op_a,
    input  logic [ADDR_W-1:0] op_b,
    input  logic [ADDR_W-1:0] op_c,
    output logic [ADDR_W-1:0] sum
);
    // modulo-2^ADDR_W addition; carries out of the top bit are dropped
    always_comb begin
        sum = op_a + op_b + op_c;
    end

endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int ADDR_W   = 32,
    parameter int SCALE_W  = 2,
    parameter int NARROW_W = 8,
    parameter int MID_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         mode,
    input  logic [1:0]         disp_size,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  index,
    input  logic [SCALE_W-1:0] scale,
    input  logic [ADDR_W-1:0]  disp,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  ea
);
    import ea_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } ea_state_t;

    ea_state_t state_d, state_q;
    ea_sel_t   sel;

    logic [ADDR_W-1:0] disp_x, index_x;
    logic [ADDR_W-1:0] op_base, op_index, op_disp, sum_w;

    ea_disp_ext #(
        .ADDR_W  (ADDR_W),
        .NARROW_W(NARROW_W),
        .MID_W   (MID_W)
    ) u_disp (
        .disp_raw (disp),
        .size_code(disp_size),
        .disp_ext (disp_x)
    );

    ea_index_scale #(
        .ADDR_W (ADDR_W),
        .SCALE_W(SCALE_W)
    ) u_scale (
        .index_raw   (index),
        .scale_code  (scale),
        .index_scaled(index_x)
    );

    // mode decode: which operands take part in the sum
    always_comb begin
        sel = '0;
        unique case (mode)
            EA_DIRECT:         sel = '{use_base: 1'b0, use_index: 1'b0, use_disp: 1'b1};
            EA_INDIRECT:       sel = '{use_base: 1'b1, use_index: 1'b0, use_disp: 1'b0};
            EA_BASE_DISP:      sel = '{use_base: 1'b1, use_index: 1'b0, use_disp: 1'b1};
            EA_BASE_INDEX:     sel = '{use_base: 1'b1, use_index: 1'b1, use_disp: 1'b0};
            EA_BASE_INDEX_DSP: sel = '{use_base: 1'b1, use_index: 1'b1, use_disp: 1'b1};
            default:           sel = '0;  // reserved codes yield zero
        endcase
    end

    assign op_base  = sel.use_base  ? base    : '0;
    assign op_index = sel.use_index ? index_x : '0;
    assign op_disp  = sel.use_disp  ? disp_x  : '0;

    ea_sum3 #(.ADDR_W(ADDR_W)) u_sum (
        .op_a(op_base),
        .op_b(op_index),
        .op_c(op_disp),
        .sum (sum_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.addr = sum_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign ea        = state_q.addr;

    // R2: valid follows the request by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3: address held while idle
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ea));
    // R5: indirect returns the base unchanged
    a_r5_indirect: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd1) |=> (ea == $past(base)));
    // R4 / R9: direct byte displacement keeps its low byte and sign-fills
    a_r9_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0 && disp_size == 2'd0)
        |=> (ea[NARROW_W-1:0] == $past(disp[NARROW_W-1:0])) &&
            ($countones(ea[ADDR_W-1:NARROW_W]) == ($past(disp[NARROW_W-1]) ? ADDR_W-NARROW_W : 0)));
    // R7: with a zero base the shifted index has cleared low bits
    a_r7_scale_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd3 && base == '0 && scale == SCALE_W'(1))
        |=> (ea[0] == 1'b0));
    // R11: reserved codes give zero
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode > 3'd4) |=> (ea == '0));

endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  disp_size = '0;
    logic [31:0] base = '0, index = '0, disp = '0;
    logic [1:0]  scale = '0;
    logic        out_valid;
    logic [31:0] ea;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .disp_size(disp_size), .base(base), .index(index), .scale(scale),
        .disp(disp), .out_valid(out_valid), .ea(ea)
    );

    // arithmetic model of the displacement extension (R9)
    function automatic longint ext_disp(input logic [31:0] d, input logic [1:0] sz);
        longint v;
        if (sz == 2'd0) begin
            v = longint'(d) % 256;
            if (v >= 128) v = v - 256;
        end else if (sz == 2'd1) begin
            v = longint'(d) % 65536;
            if (v >= 32768) v = v - 65536;
        end else begin
            v = longint'(d);
        end
        return v;
    endfunction

    function automatic logic [31:0] model(input logic [2:0] m, input logic [1:0] sz,
                                          input logic [31:0] b, input logic [31:0] i,
                                          input logic [1:0] s, input logic [31:0] d);
        longint t;
        longint sc;
        sc = longint'(i) * (64'd1 << s);
        case (m)
            3'd0: t = ext_disp(d, sz);
            3'd1: t = longint'(b);
            3'd2: t = longint'(b) + ext_disp(d, sz);
            3'd3: t = longint'(b) + sc;
            3'd4: t = longint'(b) + sc + ext_disp(d, sz);
            default: t = 0;
        endcase
        t = t % 64'sh1_0000_0000;
        if (t < 0) t = t + 64'sh1_0000_0000;
        return t[31:0];
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R4/R9/R10";
            3'd1: return "R5";
            3'd2: return "R6/R9/R10";
            3'd3: return "R7/R10";
            3'd4: return "R8/R9/R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [1:0] sz, input logic [31:0] b,
                         input logic [31:0] i, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; mode = m; disp_size = sz;
        base = b; index = i; scale = s; disp = d;
        @(posedge clk);
        #1;
        check("R2 out_valid", {31'd0, out_valid}, 32'd1);
        check(tag_of(m), ea, model(m, sz, b, i, s, d));
    endtask

    logic [31:0] bases [6] = '{32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF,
                               32'h8000_0000, 32'h0000_1000, 32'hFFFF_FF00};
    logic [31:0] idxs  [6] = '{32'h0000_0000, 32'h0000_0003, 32'h4000_0001,
                               32'hFFFF_FFFF, 32'h2000_0000, 32'h0000_0101};
    logic [31:0] disps [6] = '{32'h0000_0000, 32'hABCD_EF80, 32'h5555_7FFF,
                               32'h0000_00FF, 32'hFFFF_8001, 32'h7FFF_FF7F};

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] held;
        // R1: reset state
        base = 32'hDEAD_BEEF; disp = 32'h1111_1111; mode = 3'd2;
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 ea", ea, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // sweep: every mode, size, scale, operand pattern
        for (int m = 0; m < 8; m++)
            for (int sz = 0; sz < 4; sz++)
                for (int s = 0; s < 4; s++)
                    for (int p = 0; p < 6; p++)
                        apply(3'(m), 2'(sz), bases[p], idxs[(p + s) % 6], 2'(s), disps[(p + sz) % 6]);

        // R10: explicit wrap
        apply(3'd4, 2'd2, 32'hFFFF_FFFF, 32'h8000_0000, 2'd1, 32'h0000_0002);
        check("R10 wrap", ea, 32'h0000_0001);

        // R3: hold while idle, with every input changed
        apply(3'd2, 2'd0, 32'h0000_0100, 32'h0, 2'd0, 32'h0000_0080);
        held = ea;
        check("R9 byte sext", held, 32'h0000_0080);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b0; mode = 3'(k); base = 32'h3333_0000 + 32'(k);
            index = 32'h77; disp = 32'hFFFF_FFF0; scale = 2'(k); disp_size = 2'(k);
            @(posedge clk);
            #1;
            check("R3 hold", ea, held);
            check("R2 idle", {31'd0, out_valid}, 32'd0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule